// File: doc/BRIEF.md
# Configurable Ready/Busy Status Pin

This block drives a single open-drain status pin for a flash memory controller. It watches the busy flag, the operation class and the suspend flag of the program/erase engine. It then either holds the pin low for as long as the engine works, or gives a short low pulse when an operation of a selected class finishes. The pulse can serve as a maskable completion interrupt. The external pull-up and the interrupt logic that consumes the pulse sit outside the block.

Software picks the behaviour with a two-write configuration command on a byte-wide write bus. The first write is the prefix byte B8h and the second is the mode byte. After reset or deep power-down the pin acts as a plain ready/busy line. The block has two outputs: one enables the low driver, and its complement marks the pin as released (high impedance).

Top module: `stsPinCtrl`

## Requirements
- R1: After `rstN` is deasserted the block is in level mode with the pin released (`pinDriveLow`=0, `pinRelease`=1).
- R2: In level mode (mode byte 00h), `pinDriveLow` is 1 in the cycle after each rising clock edge at which `engBusy` is 1, and 0 in the cycle after each edge at which it is 0. This holds for every operation class: `opClass` 00 is erase, 01 is write and 10 is lock-bit configuration.
- R3: In level mode, a suspended engine (`engSuspended`=1 with `engBusy`=0) leaves the pin released. A nested write run during the suspension (`engBusy`=1) drives it low.
- R4: The mode changes only through a write of B8h on `cfgData` with `cfgWrEn`=1, followed by a later write of the mode byte. Any number of idle cycles may lie between the two writes. Mode byte 01h selects pulses on erase completion, 02h on write completion, 03h on either, and 00h selects level mode.
- R5: A mode byte with any of bits 7..2 set leaves the mode unchanged and cancels the pending prefix. A first write other than B8h is ignored.
- R6: In a pulse mode, a completion is an edge at which `engBusy` is seen 0 after being 1 on the previous edge, and `engSuspended` is not rising at that same edge. A completion of a selected class drives the pin low for exactly 8 cycles starting right after that edge. The pin is otherwise released, including while the engine is busy.
- R7: A completion whose class the current pulse mode does not select gives no pulse. Lock-bit completions never give a pulse.
- R8: In a pulse mode, busy falling in the same edge as `engSuspended` rises gives no pulse. A nested write that completes while `engSuspended` stays 1 gives a write pulse.
- R9: A selected completion that arrives while a pulse is running restarts the 8-cycle count.
- R10: While `deepPd` is 1 the pin is released in the same cycle and any running pulse is cancelled. The mode returns to level and a pending B8h prefix is discarded.
- R11: `pinRelease` is always the complement of `pinDriveLow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| engBusy | input | 1 | Engine is executing an operation |
| opClass | input | 2 | Class of the running operation: 00 erase, 01 write, 10 lock-bit |
| engSuspended | input | 1 | Engine operation is suspended |
| deepPd | input | 1 | Deep power-down request, active high |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgData | input | 8 | Configuration write data |
| pinDriveLow | output | 1 | Enable for the low driver of the status pin |
| pinRelease | output | 1 | Pin released to high impedance |

## Verification
Every cycle, the in-line assertions check the following. The pulse counter only counts down after it is loaded. It stays at zero unless a qualified completion arrives. Deep power-down clears it and restores level mode. The mode register holds unless a valid mode byte completes the sequence, and deep power-down releases the pin at once. Some behaviours can only be shown by the directed scenarios: the exact 8-cycle pulse width, the class filter for each mode byte, suspend versus nested-write completions, pulse restart, and the discarding of a prefix across power-down.

// File: rtl/stsPinPkg.sv
`timescale 1ns/1ps
package stsPinPkg;

  typedef enum logic [1:0] {
    MODE_LEVEL = 2'd0,
    MODE_ERASE = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_ANY   = 2'd3
  } stsMode_e;

  typedef enum logic [1:0] {
    OP_ERASE = 2'd0,
    OP_WRITE = 2'd1,
    OP_LOCK  = 2'd2,
    OP_RSVD  = 2'd3
  } opClass_e;

  typedef struct packed {
    logic levelMode;
    logic levelBusy;
    logic fire;
    logic cancel;
  } stsStrobe_t;

endpackage

// File: rtl/stsCfgCtrl.sv
`timescale 1ns/1ps
module stsCfgCtrl
  import stsPinPkg::*;
#(
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] CFG_PREFIX = 8'hB8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             engBusy,
  input  logic [1:0]       opClass,
  input  logic             engSuspended,
  input  logic             deepPd,
  input  logic             cfgWrEn,
  input  logic [CMD_W-1:0] cfgData,
  output stsStrobe_t       strobe
);

  localparam int MODE_W = 2;

  stsMode_e modeQ;
  opClass_e classQ;
  logic     armedQ;
  logic     busyQ;
  logic     susQ;
  logic     validMode;
  logic     suspendEdge;
  logic     doneNow;
  logic     classHit;

  assign validMode = (cfgData[CMD_W-1:MODE_W] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_LEVEL;
      classQ <= OP_ERASE;
      armedQ <= 1'b0;
      busyQ  <= 1'b0;
      susQ   <= 1'b0;
    end else if (deepPd) begin
      modeQ  <= MODE_LEVEL;
      armedQ <= 1'b0;
      busyQ  <= 1'b0;
      susQ   <= 1'b0;
    end else begin
      busyQ <= engBusy;
      susQ  <= engSuspended;
      if (engBusy) classQ <= opClass_e'(opClass);
      if (cfgWrEn) begin
        if (armedQ) begin
          armedQ <= 1'b0;
          if (validMode) modeQ <= stsMode_e'(cfgData[MODE_W-1:0]);
        end else if (cfgData == CFG_PREFIX) begin
          armedQ <= 1'b1;
        end
      end
    end
  end

  assign suspendEdge = engSuspended & ~susQ;
  assign doneNow     = busyQ & ~engBusy & ~suspendEdge & ~deepPd;

  always_comb begin
    unique case (classQ)
      OP_ERASE: classHit = modeQ[0];
      OP_WRITE: classHit = modeQ[1];
      default:  classHit = 1'b0;
    endcase
  end

  assign strobe.levelMode = (modeQ == MODE_LEVEL);
  assign strobe.levelBusy = busyQ;
  assign strobe.fire      = doneNow & classHit;
  assign strobe.cancel    = deepPd;

  AST_DPD_TO_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    $past(deepPd) |-> (modeQ == MODE_LEVEL) && !armedQ); // R10

  AST_BAD_MODE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && armedQ && !validMode && !deepPd) |=> (modeQ == $past(modeQ))); // R5

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWrEn && !deepPd) |=> $stable(modeQ)); // R4

  AST_NO_FIRE_WHEN_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    $past(!cfgWrEn && !deepPd && modeQ == MODE_LEVEL) |-> !strobe.fire); // R2

endmodule

// File: rtl/stsPinPath.sv
`timescale 1ns/1ps
module stsPinPath
  import stsPinPkg::*;
#(
  parameter int PULSE_LEN = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  stsStrobe_t strobe,
  output logic       pinDriveLow,
  output logic       pinRelease
);

  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cntQ;
  logic             pulseOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cntQ <= '0;
    else if (strobe.cancel)  cntQ <= '0;
    else if (strobe.fire)    cntQ <= CNT_W'(PULSE_LEN);
    else if (cntQ != '0)     cntQ <= cntQ - 1'b1;
  end

  assign pulseOn     = (cntQ != '0);
  assign pinDriveLow = ~strobe.cancel & (strobe.levelMode ? strobe.levelBusy : pulseOn);
  assign pinRelease  = ~pinDriveLow;

  AST_PULSE_COUNTDOWN: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ != '0 && !strobe.fire && !strobe.cancel) |=> (cntQ == $past(cntQ) - 1'b1)); // R6

  AST_PULSE_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == '0 && !strobe.fire) |=> (cntQ == '0)); // R6

  AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cancel |=> (cntQ == '0)); // R10

endmodule

// File: rtl/stsPinCtrl.sv
`timescale 1ns/1ps
module stsPinCtrl
  import stsPinPkg::*;
#(
  parameter int CMD_W = 8,
  parameter int PULSE_LEN = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             engBusy,
  input  logic [1:0]       opClass,
  input  logic             engSuspended,
  input  logic             deepPd,
  input  logic             cfgWrEn,
  input  logic [CMD_W-1:0] cfgData,
  output logic             pinDriveLow,
  output logic             pinRelease
);

  stsStrobe_t strobe;

  stsCfgCtrl #(.CMD_W(CMD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .engBusy(engBusy), .opClass(opClass),
    .engSuspended(engSuspended), .deepPd(deepPd),
    .cfgWrEn(cfgWrEn), .cfgData(cfgData), .strobe(strobe)
  );

  stsPinPath #(.PULSE_LEN(PULSE_LEN)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pinDriveLow(pinDriveLow), .pinRelease(pinRelease)
  );

  AST_DPD_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    deepPd |-> (pinRelease && !pinDriveLow)); // R10

endmodule

// File: tb/stsPinCtrl_test.sv
`timescale 1ns/1ps
module stsPinCtrl_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       engBusy = 1'b0;
  logic [1:0] opClass = 2'd0;
  logic       engSuspended = 1'b0;
  logic       deepPd = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgData = 8'h00;
  logic       pinDriveLow;
  logic       pinRelease;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [1:0] C_ERASE = 2'd0;
  localparam logic [1:0] C_WRITE = 2'd1;
  localparam logic [1:0] C_LOCK  = 2'd2;

  always #2.5 clk = ~clk;

  stsPinCtrl uut (
    .clk(clk), .rstN(rstN), .engBusy(engBusy), .opClass(opClass),
    .engSuspended(engSuspended), .deepPd(deepPd), .cfgWrEn(cfgWrEn),
    .cfgData(cfgData), .pinDriveLow(pinDriveLow), .pinRelease(pinRelease)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] d);
    cfgWrEn = 1'b1;
    cfgData = d;
    tick();
    cfgWrEn = 1'b0;
    cfgData = 8'h00;
  endtask

  // Runs one operation; counts low-drive samples while busy and for 12 cycles after.
  task automatic runOp(input logic [1:0] cls, input int busyLen,
                       output int lowDuring, output int lowAfter, output int badPair);
    lowDuring = 0;
    lowAfter  = 0;
    badPair   = 0;
    opClass = cls;
    engBusy = 1'b1;
    for (int i = 0; i < busyLen; i++) begin
      tick();
      if (pinDriveLow) lowDuring++;
      if (pinRelease == pinDriveLow) badPair++;
    end
    engBusy = 1'b0;
    for (int i = 0; i < 12; i++) begin
      tick();
      if (pinDriveLow) lowAfter++;
      if (pinRelease == pinDriveLow) badPair++;
    end
  endtask

  task automatic tReset();
    int d, a, b;
    chkEq("R1 drive after reset", pinDriveLow, 0);
    chkEq("R1 release after reset", pinRelease, 1);
    runOp(C_ERASE, 5, d, a, b);
    chkEq("R1 R2 level erase busy low", d, 5);
    chkEq("R2 level erase released after", a, 0);
    chkEq("R11 complement", b, 0);
  endtask

  task automatic tLevelLock();
    int d, a, b;
    runOp(C_LOCK, 3, d, a, b);
    chkEq("R2 level lock busy low", d, 3);
    chkEq("R2 level lock released after", a, 0);
  endtask

  task automatic tLevelSuspend();
    opClass = C_ERASE;
    engBusy = 1'b1;
    tick(); tick();
    chkEq("R3 level erase running", pinDriveLow, 1);
    engBusy = 1'b0;
    engSuspended = 1'b1;
    tick();
    chkEq("R3 suspended released", pinRelease, 1);
    opClass = C_WRITE;
    engBusy = 1'b1;
    tick();
    chkEq("R3 nested write drives", pinDriveLow, 1);
    engBusy = 1'b0;
    tick();
    chkEq("R3 nested write done released", pinDriveLow, 0);
    engSuspended = 1'b0;
    tick();
  endtask

  task automatic tCfgErase();
    int d, a, b;
    cfgWrite(8'hB8);
    cfgWrite(8'h01);
    runOp(C_ERASE, 4, d, a, b);
    chkEq("R6 pulse mode busy released", d, 0);
    chkEq("R4 R6 erase pulse width", a, 8);
    chkEq("R11 complement pulse", b, 0);
    runOp(C_WRITE, 4, d, a, b);
    chkEq("R7 erase-mode ignores write", d + a, 0);
    runOp(C_LOCK, 4, d, a, b);
    chkEq("R7 erase-mode ignores lock", d + a, 0);
  endtask

  task automatic tCfgWrite();
    int d, a, b;
    cfgWrite(8'hB8);
    tick(); tick(); tick();
    cfgWrite(8'h02);
    runOp(C_WRITE, 3, d, a, b);
    chkEq("R4 write pulse after gap", a, 8);
    runOp(C_ERASE, 3, d, a, b);
    chkEq("R7 write-mode ignores erase", d + a, 0);
  endtask

  task automatic tCfgAny();
    int d, a, b;
    cfgWrite(8'hB8);
    cfgWrite(8'h03);
    runOp(C_ERASE, 2, d, a, b);
    chkEq("R7 any-mode erase pulse", a, 8);
    runOp(C_WRITE, 2, d, a, b);
    chkEq("R7 any-mode write pulse", a, 8);
    runOp(C_LOCK, 2, d, a, b);
    chkEq("R7 any-mode lock no pulse", d + a, 0);
  endtask

  task automatic tInvalid();
    int d, a, b;
    cfgWrite(8'hB8);
    cfgWrite(8'h07);
    runOp(C_WRITE, 2, d, a, b);
    chkEq("R5 bad mode byte ignored", a, 8);
    cfgWrite(8'h01);
    runOp(C_WRITE, 2, d, a, b);
    chkEq("R5 unprefixed byte ignored", a, 8);
    cfgWrite(8'hB8);
    cfgWrite(8'hB8);
    cfgWrite(8'h01);
    runOp(C_WRITE, 2, d, a, b);
    chkEq("R5 prefix dropped after bad byte", a, 8);
  endtask

  task automatic tSuspendPulse();
    int lows;
    opClass = C_ERASE;
    engBusy = 1'b1;
    tick(); tick(); tick();
    engBusy = 1'b0;
    engSuspended = 1'b1;
    lows = 0;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (pinDriveLow) lows++;
    end
    chkEq("R8 suspend gives no pulse", lows, 0);
    opClass = C_WRITE;
    engBusy = 1'b1;
    tick(); tick();
    engBusy = 1'b0;
    lows = 0;
    for (int i = 0; i < 12; i++) begin
      tick();
      if (pinDriveLow) lows++;
    end
    chkEq("R8 nested write pulse", lows, 8);
    engSuspended = 1'b0;
    tick();
  endtask

  task automatic tRetrigger();
    int lows;
    opClass = C_ERASE;
    engBusy = 1'b1;
    tick(); tick();
    engBusy = 1'b0;
    lows = 0;
    for (int i = 0; i < 3; i++) begin
      tick();
      if (pinDriveLow) lows++;
    end
    engBusy = 1'b1;
    tick();
    if (pinDriveLow) lows++;
    engBusy = 1'b0;
    for (int i = 0; i < 14; i++) begin
      tick();
      if (pinDriveLow) lows++;
    end
    chkEq("R9 retrigger total low", lows, 12);
  endtask

  task automatic tDeepPd();
    int d, a, b;
    cfgWrite(8'hB8);
    cfgWrite(8'h01);
    opClass = C_ERASE;
    engBusy = 1'b1;
    tick(); tick();
    engBusy = 1'b0;
    tick(); tick();
    chkEq("R6 pulse running before power-down", pinDriveLow, 1);
    deepPd = 1'b1;
    #1;
    chkEq("R10 immediate release", pinRelease, 1);
    tick();
    deepPd = 1'b0;
    tick();
    chkEq("R10 pulse cancelled", pinDriveLow, 0);
    runOp(C_ERASE, 3, d, a, b);
    chkEq("R10 back to level mode", d, 3);
    cfgWrite(8'hB8);
    deepPd = 1'b1;
    tick();
    deepPd = 1'b0;
    tick();
    cfgWrite(8'h02);
    runOp(C_WRITE, 3, d, a, b);
    chkEq("R10 prefix discarded", d, 3);
    chkEq("R10 prefix discarded no pulse", a, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    tReset();
    tLevelLock();
    tLevelSuspend();
    tCfgErase();
    tCfgWrite();
    tCfgAny();
    tInvalid();
    tSuspendPulse();
    tRetrigger();
    tDeepPd();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule